// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command and address pins of a four-bank single-data-rate SDRAM. On every rising clock edge it samples chip select, the three strobes and the fourteen address pins. It classifies the pin state as one command and reports that command in the next cycle, together with the addressed bank, the row field and the column field. The column field is 8, 9 or 10 bits wide, depending on the data width of the device organization.

Alongside the decoder it keeps a model of the device. For each bank it holds an open or idle flag and the open row. It also holds a copy of the mode register and a flag that records whether the mode register has been programmed since reset. From this state it judges each command. A command that the device would not accept in its present state raises a one-cycle violation flag. Such a command leaves the model unchanged. Auto-precharge accesses close their bank once the burst length held in the mode register has run out.

The block is meant for protocol monitoring, either next to a memory controller or inside a device model.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: With cs_n high the command is deselect (code 1). With cs_n low, {ras_n,cas_n,we_n} decode as follows: 011 activate (2); 101 read (3, or 4 with auto-precharge when A10 is high); 100 write (5, or 6 when A10 is high); 010 precharge one bank (7, or precharge all banks, 8, when A10 is high); 001 refresh (9); 000 mode register set (10); 111 and 110 no-operation (0). The code appears on cmd_o one cycle after the sampling edge.
- R2: Pins A13:A12 select the bank, as bank = {A13,A12}. row_o carries A11:A0. col_o carries A(COL_W-1):A0, where COL_W is 8, 9 or 10 for ORG 16, 8 or 4. All three outputs are registered alongside cmd_o.
- R3: After reset all banks are idle, mode_valid_o is 0, viol_o is 0 and cmd_o is no-operation.
- R4: An activate to an idle bank opens that bank and stores A11:A0 as its open row (open_row_o slice b·12 upward). An activate to an open bank raises viol_o and leaves the stored row unchanged.
- R5: A read or write, with or without auto-precharge, to an idle bank raises viol_o.
- R6: A read or write issued before the first accepted mode register set raises viol_o and does not start an auto-precharge.
- R7: Precharge of one bank closes only the selected bank. Precharge all banks closes all four. Precharge of an idle bank is legal.
- R8: A mode register set while all banks are idle loads A13:A0 into mode_o and sets mode_valid_o. A mode register set or a refresh while any bank is open raises viol_o, and the ignored mode register set leaves mode_o unchanged.
- R9: Mode bits A2:A0 give the burst length: 000 is 1, 001 is 2, 010 is 4, 011 is 8, 111 is full page, and the other codes act as length 1. After an accepted auto-precharge access issued at edge E, bank_open_o of that bank stays 1 through edge E+BL-1 and is 0 after edge E+BL.
- R10: A read with auto-precharge raises viol_o when the burst field is full page (111), and the bank stays open. A write with auto-precharge does the same unless mode bit A9 (single write) is 1. With A9 set, a write with auto-precharge is legal and uses length 1 whatever the burst field holds.
- R11: A read or write to a bank whose auto-precharge is still pending raises viol_o. A precharge of that bank closes it at once and cancels the pending close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 14 | Address pins A13..A0 |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_o | output | 2 | Bank of the decoded command |
| row_o | output | 12 | Row field A11:A0 |
| col_o | output | COL_W | Column field |
| viol_o | output | 1 | Sequence violation for the decoded command |
| mode_o | output | 14 | Stored mode register |
| mode_valid_o | output | 1 | Mode register programmed since reset |
| bank_open_o | output | 4 | Per-bank open flag |
| open_row_o | output | 48 | Open row per bank, 12 bits each, bank 0 lowest |

## Verification
All per-command results (cmd_o, bank_o, row_o, col_o, viol_o) and the bank and mode state updates appear one cycle after the edge that samples the pins. The bench therefore drives pins on a falling edge and reads every result on the next falling edge. Auto-precharge closing is due BL edges after the command. The bench samples bank_open_o on each of the falling edges that follow and expects it to drop on exactly the BL-th one. Decode is checked by sweeping all pin and A10 combinations. Bank state is swept over every bank and every finite burst length.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_RDA   = 4'd4,
    CMD_WR    = 4'd5,
    CMD_WRA   = 4'd6,
    CMD_PRE   = 4'd7,
    CMD_PALL  = 4'd8,
    CMD_REF   = 4'd9,
    CMD_MRS   = 4'd10
  } cmd_e;

  // column width from the data width of the organization
  function automatic int col_width(input int org);
    if (org == 4) return 10;
    else if (org == 8) return 9;
    else return 8;
  endfunction

  // burst field to beat count; full page and reserved codes give 1
  function automatic logic [3:0] burst_beats(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd2;
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ap_bit,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = ap_bit ? CMD_RDA : CMD_RD;
        3'b100:  cmd = ap_bit ? CMD_WRA : CMD_WR;
        3'b010:  cmd = ap_bit ? CMD_PALL : CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdr_mode_store.sv
module sdr_mode_store #(
  parameter int ADDR_W = 14
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] mode_o,
  output logic              valid_o
);

  logic [ADDR_W-1:0] mode_q, mode_d;
  logic              valid_q, valid_d;

  always_comb begin
    mode_d  = mode_q;
    valid_d = valid_q;
    if (load) begin
      mode_d  = din;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      mode_q  <= mode_d;
      valid_q <= valid_d;
    end
  end

  assign mode_o  = mode_q;
  assign valid_o = valid_q;

  // once programmed, the mode stays valid until reset
  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);

endmodule

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic             ap_go,
  input  logic [CNT_W-1:0] ap_len,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);

  logic             open_q, open_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q;
  logic             st_en;

  assign st_en = pre_go | act_go | ap_go | pend_q;

  always_comb begin
    open_d = open_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (pre_go) begin
      open_d = 1'b0;
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (act_go) begin
      open_d = 1'b1;
    end else if (ap_go) begin
      pend_d = 1'b1;
      cnt_d  = ap_len;
    end else if (pend_q) begin
      if (cnt_q == CNT_W'(1)) begin
        open_d = 1'b0;
        pend_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (st_en) begin
      open_q <= open_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else if (act_go) row_q <= row_in;
  end

  assign open_o = open_q;
  assign pend_o = pend_q;
  assign row_o  = row_q;

  p_act_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> (open_q && row_q == $past(row_in)));

  p_pre_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |=> (!open_q && !pend_q));

  p_ap_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q == CNT_W'(1) && !pre_go) |=> !open_q);

  p_pend_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> open_q);

endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
  import sdr_trk_pkg::*;
#(
  parameter int ORG    = 16,
  parameter int ROW_W  = 12,
  parameter int ADDR_W = 14,
  parameter int NBANK  = 4,
  parameter int CNT_W  = 4,
  localparam int COL_W = col_width(ORG),
  localparam int BSEL_W = $clog2(NBANK)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [ADDR_W-1:0]      addr,
  output logic [3:0]             cmd_o,
  output logic [BSEL_W-1:0]      bank_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic                   viol_o,
  output logic [ADDR_W-1:0]      mode_o,
  output logic                   mode_valid_o,
  output logic [NBANK-1:0]       bank_open_o,
  output logic [NBANK*ROW_W-1:0] open_row_o
);

  localparam int AP_BIT  = 10;
  localparam int SW_BIT  = 9;
  localparam logic [2:0] FULL_PAGE = 3'b111;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  // decode
  cmd_e              cmd;
  logic [BSEL_W-1:0] sel;
  assign sel = addr[ADDR_W-1 -: BSEL_W];

  sdr_cmd_decode u_dec (
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ap_bit (addr[AP_BIT]),
    .cmd    (cmd)
  );

  // state views
  logic [NBANK-1:0] bank_open, bank_pend;
  logic [ADDR_W-1:0] mode_q;
  logic              mode_valid;

  // legality
  logic is_rw, is_ap, full_page, single_wr, ap_allowed;
  logic viol_d, act_ok, pre_ok, pall_ok, ap_ok, mrs_ok;
  logic [CNT_W-1:0] ap_len;

  always_comb begin
    is_rw      = (cmd == CMD_RD) || (cmd == CMD_RDA) ||
                 (cmd == CMD_WR) || (cmd == CMD_WRA);
    is_ap      = (cmd == CMD_RDA) || (cmd == CMD_WRA);
    full_page  = (mode_q[2:0] == FULL_PAGE);
    single_wr  = mode_q[SW_BIT];
    ap_allowed = (cmd == CMD_WRA) ? (single_wr || !full_page) : !full_page;

    viol_d = 1'b0;
    if (is_rw && !mode_valid)                  viol_d = 1'b1;
    if (is_rw && !bank_open[sel])              viol_d = 1'b1;
    if (is_rw && bank_pend[sel])               viol_d = 1'b1;
    if (is_ap && mode_valid && !ap_allowed)    viol_d = 1'b1;
    if ((cmd == CMD_ACT) && bank_open[sel])    viol_d = 1'b1;
    if (((cmd == CMD_REF) || (cmd == CMD_MRS)) && (|bank_open)) viol_d = 1'b1;

    act_ok  = (cmd == CMD_ACT) && !viol_d;
    pre_ok  = (cmd == CMD_PRE);
    pall_ok = (cmd == CMD_PALL);
    ap_ok   = is_ap && !viol_d;
    mrs_ok  = (cmd == CMD_MRS) && !viol_d;

    if ((cmd == CMD_WRA) && single_wr) ap_len = CNT_W'(1);
    else                               ap_len = CNT_W'(burst_beats(mode_q[2:0]));
  end

  sdr_mode_store #(.ADDR_W(ADDR_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_i),
    .load    (mrs_ok),
    .din     (addr),
    .mode_o  (mode_q),
    .valid_o (mode_valid)
  );

  // one slot per bank
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    logic [ROW_W-1:0] row_b;
    assign hit = (sel == BSEL_W'(b));

    sdr_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_i),
      .act_go (act_ok && hit),
      .pre_go ((pre_ok && hit) || pall_ok),
      .ap_go  (ap_ok && hit),
      .ap_len (ap_len),
      .row_in (addr[ROW_W-1:0]),
      .open_o (bank_open[b]),
      .pend_o (bank_pend[b]),
      .row_o  (row_b)
    );
    assign open_row_o[b*ROW_W +: ROW_W] = row_b;
  end

  // per-command output register
  logic [3:0]        cmd_q;
  logic [BSEL_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              viol_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      cmd_q  <= cmd;
      bank_q <= sel;
      row_q  <= addr[ROW_W-1:0];
      col_q  <= addr[COL_W-1:0];
      viol_q <= viol_d;
    end
  end

  assign cmd_o        = cmd_q;
  assign bank_o       = bank_q;
  assign row_o        = row_q;
  assign col_o        = col_q;
  assign viol_o       = viol_q;
  assign mode_o       = mode_q;
  assign mode_valid_o = mode_valid;
  assign bank_open_o  = bank_open;

  p_rw_idle_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (is_rw && !bank_open[sel]) |=> viol_o);

  p_rw_unset_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (is_rw && !mode_valid) |=> (viol_o && !(|bank_pend)));

  p_act_busy_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd == CMD_ACT && bank_open[sel]) |=> (viol_o && $stable(open_row_o)));

  p_pall_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd == CMD_PALL) |=> (bank_open_o == '0));

  p_mrs_busy_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd == CMD_MRS && (|bank_open)) |=> (viol_o && $stable(mode_o)));

  p_full_rda_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd == CMD_RDA && mode_valid && mode_q[2:0] == FULL_PAGE) |=> viol_o);

endmodule

// File: tb/sdr_cmd_tracker_test.sv
module sdr_cmd_tracker_test;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_MRS = 4'b0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [13:0] addr;
  logic [3:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [11:0] row_o;
  logic [7:0]  col_o;
  logic        viol_o;
  logic [13:0] mode_o;
  logic        mode_valid_o;
  logic [3:0]  bank_open_o;
  logic [47:0] open_row_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdr_cmd_tracker uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o),
    .col_o(col_o), .viol_o(viol_o), .mode_o(mode_o),
    .mode_valid_o(mode_valid_o), .bank_open_o(bank_open_o),
    .open_row_o(open_row_o)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input logic [1:0] bank, input logic a10,
                                     input logic [11:0] low);
    return {bank, low[11], a10, low[9:0]};
  endfunction

  function automatic logic [13:0] mword(input logic sw, input logic [2:0] bl);
    return {4'b0000, sw, 2'b00, 3'b010, 1'b0, bl};
  endfunction

  function automatic logic [3:0] exp_cmd(input logic [3:0] p, input logic a10);
    if (p[3]) return 4'd1;
    case (p[2:0])
      3'b011:  return 4'd2;
      3'b101:  return a10 ? 4'd4 : 4'd3;
      3'b100:  return a10 ? 4'd6 : 4'd5;
      3'b010:  return a10 ? 4'd8 : 4'd7;
      3'b001:  return 4'd9;
      3'b000:  return 4'd10;
      default: return 4'd0;
    endcase
  endfunction

  function automatic int beats(input logic [2:0] bl);
    return (bl == 3'd1) ? 2 : (bl == 3'd2) ? 4 : (bl == 3'd3) ? 8 : 1;
  endfunction

  // drive one command for one edge; results readable on return
  task automatic put(input logic [3:0] p, input logic [13:0] a);
    {cs_n, ras_n, cas_n, we_n} = p;
    addr = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    addr = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pall();
    put(P_PRE, mk(2'd0, 1'b1, 12'h0));
  endtask

  initial begin
    do_reset();
    // R3 reset state
    chk("R3 cmd", cmd_o, 4'd0);
    chk("R3 open", bank_open_o, 4'h0);
    chk("R3 mode_valid", mode_valid_o, 1'b0);
    chk("R3 viol", viol_o, 1'b0);

    // R1/R2 decode sweep over every pin state and A10
    for (int c = 0; c < 32; c++) begin
      logic [3:0]  p;
      logic [13:0] a;
      p = 4'(c >> 1);
      a = {2'(c), 1'(c >> 2), 1'(c), 10'(c * 37 + 5)};
      put(p, a);
      chk("R1 decode", cmd_o, exp_cmd(p, c[0]));
      chk("R2 bank", bank_o, a[13:12]);
      chk("R2 row", row_o, a[11:0]);
      chk("R2 col", col_o, a[7:0]);
    end

    // R6 accesses before the mode register is programmed
    do_reset();
    put(P_ACT, mk(2'd0, 1'b0, 12'h055));
    chk("R6 act before mode", viol_o, 1'b0);
    put(P_RD, mk(2'd0, 1'b0, 12'h010));
    chk("R6 read before mode", viol_o, 1'b1);
    put(P_WR, mk(2'd0, 1'b1, 12'h010));
    chk("R6 write-ap before mode", viol_o, 1'b1);
    repeat (9) @(negedge clk);
    chk("R6 no ap started", bank_open_o[0], 1'b1);
    chk("R6 mode_valid", mode_valid_o, 1'b0);
    pall();

    // R8 program mode
    put(P_MRS, mword(1'b0, 3'd0));
    chk("R8 mrs viol", viol_o, 1'b0);
    chk("R8 mode_o", mode_o, mword(1'b0, 3'd0));
    chk("R8 mode_valid", mode_valid_o, 1'b1);

    // R5 / R4 per bank
    for (int b = 0; b < 4; b++) begin
      logic [11:0] r;
      r = 12'(12'h123 + b * 12'h2F1);
      put(P_RD, mk(2'(b), 1'b0, 12'h004));
      chk("R5 read idle bank", viol_o, 1'b1);
      put(P_WR, mk(2'(b), 1'b0, 12'h004));
      chk("R5 write idle bank", viol_o, 1'b1);
      put(P_ACT, mk(2'(b), r[10], r));
      chk("R4 act viol", viol_o, 1'b0);
      chk("R4 open", bank_open_o[b], 1'b1);
      chk("R4 row", open_row_o[b*12 +: 12], r);
      put(P_ACT, mk(2'(b), 1'b0, 12'hABC));
      chk("R4 act open bank", viol_o, 1'b1);
      chk("R4 row kept", open_row_o[b*12 +: 12], r);
      put(P_RD, mk(2'(b), 1'b0, 12'h008));
      chk("R5 read open bank", viol_o, 1'b0);
    end
    chk("R4 all open", bank_open_o, 4'hF);

    // R8 refresh / mode set while open
    put(P_REF, 14'h0);
    chk("R8 refresh open", viol_o, 1'b1);
    put(P_MRS, mword(1'b1, 3'd3));
    chk("R8 mrs open viol", viol_o, 1'b1);
    chk("R8 mrs ignored", mode_o, mword(1'b0, 3'd0));

    // R7 precharge
    put(P_PRE, mk(2'd2, 1'b0, 12'h0));
    chk("R7 single pre", bank_open_o, 4'b1011);
    put(P_PRE, mk(2'd2, 1'b0, 12'h0));
    chk("R7 pre idle bank legal", viol_o, 1'b0);
    pall();
    chk("R7 pre all", bank_open_o, 4'h0);
    put(P_REF, 14'h0);
    chk("R8 refresh idle", viol_o, 1'b0);

    // R9 auto-precharge timing for all finite burst lengths and banks
    for (int bl = 0; bl < 4; bl++) begin
      put(P_MRS, mword(1'b0, 3'(bl)));
      for (int b = 0; b < 4; b++) begin
        for (int w = 0; w < 2; w++) begin
          put(P_ACT, mk(2'(b), 1'b0, 12'h321));
          put(w ? P_WR : P_RD, mk(2'(b), 1'b1, 12'h040));
          chk("R9 ap cmd", cmd_o, w ? 4'd6 : 4'd4);
          chk("R9 ap viol", viol_o, 1'b0);
          chk("R9 open at issue", bank_open_o[b], 1'b1);
          for (int k = 1; k <= beats(3'(bl)); k++) begin
            @(negedge clk);
            chk("R9 close timing", bank_open_o[b], (k < beats(3'(bl))) ? 1'b1 : 1'b0);
          end
        end
      end
    end

    // R10 single write mode: write-ap length 1 even with burst 8
    put(P_MRS, mword(1'b1, 3'd3));
    put(P_ACT, mk(2'd3, 1'b0, 12'h777));
    put(P_WR, mk(2'd3, 1'b1, 12'h001));
    chk("R10 single wr ap viol", viol_o, 1'b0);
    @(negedge clk);
    chk("R10 single wr closes after 1", bank_open_o[3], 1'b0);

    // R10 full page
    put(P_MRS, mword(1'b0, 3'd7));
    put(P_ACT, mk(2'd1, 1'b0, 12'h0F0));
    put(P_RD, mk(2'd1, 1'b1, 12'h000));
    chk("R10 full page read-ap", viol_o, 1'b1);
    put(P_WR, mk(2'd1, 1'b1, 12'h000));
    chk("R10 full page write-ap", viol_o, 1'b1);
    repeat (10) @(negedge clk);
    chk("R10 bank stays open", bank_open_o[1], 1'b1);
    pall();
    put(P_MRS, mword(1'b1, 3'd7));
    put(P_ACT, mk(2'd1, 1'b0, 12'h0F0));
    put(P_WR, mk(2'd1, 1'b1, 12'h000));
    chk("R10 full page single wr-ap", viol_o, 1'b0);
    @(negedge clk);
    chk("R10 full page single closes", bank_open_o[1], 1'b0);

    // R11 pending auto-precharge
    put(P_MRS, mword(1'b0, 3'd3));
    put(P_ACT, mk(2'd2, 1'b0, 12'h444));
    put(P_RD, mk(2'd2, 1'b1, 12'h000));
    chk("R11 ap issue", viol_o, 1'b0);
    put(P_RD, mk(2'd2, 1'b0, 12'h000));
    chk("R11 read pending", viol_o, 1'b1);
    put(P_WR, mk(2'd2, 1'b1, 12'h000));
    chk("R11 write-ap pending", viol_o, 1'b1);
    chk("R11 still open", bank_open_o[2], 1'b1);
    put(P_PRE, mk(2'd2, 1'b0, 12'h0));
    chk("R11 pre closes now", bank_open_o[2], 1'b0);
    put(P_ACT, mk(2'd2, 1'b0, 12'h555));
    repeat (10) @(negedge clk);
    chk("R11 close cancelled", bank_open_o[2], 1'b1);

    summary();
  end

endmodule